// File: doc/BRIEF.md
# Barrel Shifter with Exponent Detection and Normalization

This block is the shift unit of a 16-bit fixed-point signal-processing datapath. A 16-bit operand is first placed in the upper or the lower half of a 32-bit field. It is then moved left or right by a signed amount, and the outcome is written to a 32-bit result register. The new value can either replace the previous result or be OR-ed into it. With two operations in a row, a caller can assemble a full 32-bit word from two 16-bit halves.

The block also handles floating-point style scaling. An exponent-detect operation counts how many redundant sign bits a word carries and stores the negated count in an 8-bit exponent register. For a double word, the high half is examined first and the low half second. The low-half step only adds to the count when the high half was made entirely of sign bits. Normalize shifts left by the stored count, and denormalize shifts by the stored exponent, so a value can be scaled to full precision and back.

A small controller tracks the progress of a double-word exponent search. Its states are:
- `S_IDLE`: no search in progress.
- `S_HI_PART`: the high word held a non-sign bit.
- `S_HI_FULL`: the high word was all sign bits, so a low-word continuation is armed.

Its transitions are:
- `S_IDLE`, `S_HI_PART` or `S_HI_FULL` go to `S_HI_FULL` on a high-word detect of an all-sign word.
- The same states go to `S_HI_PART` on a high-word detect of any other word.
- Every state goes to `S_IDLE` on a low-word detect or on any other non-idle operation.
- Every state stays where it is on the idle operation.

Top module: `shf_unit`

## Requirements
- R1: While reset is held and after it is released, before any operation, the result reads 0 and the exponent reads 0.
- R2: Op code 1 is a logical shift. Placement is taken from `hi_sel_i`: 1 gives {data, 16 zeros} and 0 gives {16 zeros, data}. The placed value moves left by `amt_i` when positive and right by its magnitude when negative, with zero fill. A magnitude of 32 or more yields 0. The result appears one clock after the operation is presented.
- R3: Op code 2 is an arithmetic shift. Low placement sign-extends the data from bit 15. Right shifts fill with bit 31 of the placed value, and right magnitudes of 32 or more give all copies of that bit. Left shifts match R2.
- R4: When `or_en_i` is 1 on op codes 1 to 4, the new result is the shifted value OR-ed with the previous result. When it is 0, the shifted value replaces the previous result.
- R5: Op code 5 with `hi_sel_i`=1 (high-word detect) sets the exponent to minus the number of bits below bit 15 that match bit 15, counted from bit 14 down until the first mismatch. The range is 0 to -15. The result register is left unchanged.
- R6: Op code 5 with `hi_sel_i`=0 (low-word detect) directly after a high-word detect whose word was all sign bits sets the exponent to -15 minus the number of leading low-word bits, counted from bit 15 down, that equal the high word's sign. The range is -15 to -31.
- R7: A low-word detect leaves the exponent unchanged unless the continuation is armed. Any non-idle operation disarms it, including another low-word detect.
- R8: Op code 3 (normalize) shifts by minus the exponent register, using arithmetic placement when `hi_sel_i`=1 and logical (zero-extended) placement when it is 0.
- R9: Op code 4 (denormalize) shifts by the exponent register as a signed amount, with the same placement rule as R8.
- R10: Op code 0 and the unused codes 6 and 7 change neither the result nor the exponent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (0 idle, 1 logical, 2 arithmetic, 3 normalize, 4 denormalize, 5 exponent detect) |
| data_i | input | 16 | Operand word |
| amt_i | input | 8 | Signed shift amount for op codes 1 and 2 |
| hi_sel_i | input | 1 | 1 places the operand in the upper half, or selects the high-word detect step |
| or_en_i | input | 1 | OR the new value into the previous result |
| result_o | output | 32 | Registered result field |
| exp_o | output | 8 | Registered signed exponent |

## Verification
A wrong controller state does not show at the ports right away. It becomes visible on the next low-word detect: the exponent either stays where it should have moved below -15, or moves when it should have held. The error then reaches the result on the following normalize, so the bench checks each detect pair together with the normalize that follows it. A corrupted exponent register shows on the very next normalize or denormalize as a result shifted by the wrong distance. A bad result register shows on the next OR-mode operation, or on the first compare, since the result is checked one clock after every operation.

// File: rtl/shf_pkg.sv
package shf_pkg;
    localparam int DATA_W = 16;
    localparam int RES_W  = 2 * DATA_W;
    localparam int AMT_W  = 8;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    localparam logic [2:0] OP_NOP    = 3'd0;
    localparam logic [2:0] OP_LSH    = 3'd1;
    localparam logic [2:0] OP_ASH    = 3'd2;
    localparam logic [2:0] OP_NORM   = 3'd3;
    localparam logic [2:0] OP_DENORM = 3'd4;
    localparam logic [2:0] OP_EXP    = 3'd5;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_HI_PART = 2'd1,
        S_HI_FULL = 2'd2
    } shf_state_e;
endpackage

// File: rtl/shf_place.sv
module shf_place #(
    parameter int DW = 16,
    parameter int RW = 32
) (
    input  logic [DW-1:0] data_i,
    input  logic          hi_sel_i,
    input  logic          arith_i,
    output logic [RW-1:0] placed_o,
    output logic          fill_o
);
    localparam int PAD_W = RW - DW;

    always_comb begin
        if (hi_sel_i) begin
            placed_o = {data_i, {PAD_W{1'b0}}};
        end else if (arith_i) begin
            placed_o = {{PAD_W{data_i[DW-1]}}, data_i};
        end else begin
            placed_o = {{PAD_W{1'b0}}, data_i};
        end
        fill_o = arith_i & placed_o[RW-1];
    end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
    parameter int RW = 32,
    parameter int AW = 8
) (
    input  logic [RW-1:0] din_i,
    input  logic [AW-1:0] amt_i,
    input  logic          fill_i,
    output logic [RW-1:0] dout_o
);
    logic          go_left;
    logic [AW-1:0] mag;
    logic [RW-1:0] stg [AW+1];

    assign go_left = ~amt_i[AW-1];
    assign mag     = amt_i[AW-1] ? (~amt_i + 1'b1) : amt_i;
    assign stg[0]  = din_i;

    for (genvar i = 0; i < AW; i++) begin : g_stage
        localparam int SH = 1 << i;
        if (SH >= RW) begin : g_wide
            assign stg[i+1] = mag[i] ? (go_left ? '0 : {RW{fill_i}}) : stg[i];
        end else begin : g_narrow
            assign stg[i+1] = !mag[i] ? stg[i] :
                              go_left ? {stg[i][RW-1-SH:0], {SH{1'b0}}}
                                      : {{SH{fill_i}}, stg[i][RW-1:SH]};
        end
    end

    assign dout_o = stg[AW];
endmodule

// File: rtl/shf_signcnt.sv
module shf_signcnt #(
    parameter int DW = 16,
    parameter int CW = 5
) (
    input  logic [DW-1:0] word_i,
    input  logic          sign_i,
    output logic [CW-1:0] count_o
);
    always_comb begin
        logic run;
        run     = 1'b1;
        count_o = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (run && (word_i[i] == sign_i)) begin
                count_o = CW'(count_o + 1'b1);
            end else begin
                run = 1'b0;
            end
        end
    end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          op_i,
    input  logic [DATA_W-1:0]   data_i,
    input  logic [AMT_W-1:0]    amt_i,
    input  logic                hi_sel_i,
    input  logic                or_en_i,
    output logic [RES_W-1:0]    result_o,
    output logic [AMT_W-1:0]    exp_o
);
    shf_state_e        state_q, state_d;
    logic [RES_W-1:0]  result_q;
    logic [AMT_W-1:0]  exp_q;
    logic              sign_q;

    logic              is_shift, is_exp_hi, is_exp_lo, use_arith;
    logic [AMT_W-1:0]  eff_amt;
    logic [RES_W-1:0]  placed, shifted, merged;
    logic              fill;
    logic              cnt_sign;
    logic [CNT_W-1:0]  cnt;
    logic              all_sign;
    logic [AMT_W-1:0]  exp_hi_val, exp_lo_val;

    assign is_shift  = (op_i == OP_LSH) || (op_i == OP_ASH) ||
                       (op_i == OP_NORM) || (op_i == OP_DENORM);
    assign is_exp_hi = (op_i == OP_EXP) && hi_sel_i;
    assign is_exp_lo = (op_i == OP_EXP) && !hi_sel_i;
    assign use_arith = (op_i == OP_ASH) ||
                       (((op_i == OP_NORM) || (op_i == OP_DENORM)) && hi_sel_i);

    always_comb begin
        unique case (op_i)
            OP_NORM:   eff_amt = AMT_W'(0) - exp_q;
            OP_DENORM: eff_amt = exp_q;
            default:   eff_amt = amt_i;
        endcase
    end

    shf_place #(.DW(DATA_W), .RW(RES_W)) u_place (
        .data_i   (data_i),
        .hi_sel_i (hi_sel_i),
        .arith_i  (use_arith),
        .placed_o (placed),
        .fill_o   (fill)
    );

    shf_barrel #(.RW(RES_W), .AW(AMT_W)) u_barrel (
        .din_i  (placed),
        .amt_i  (eff_amt),
        .fill_i (fill),
        .dout_o (shifted)
    );

    assign merged = shifted | (or_en_i ? result_q : '0);

    assign cnt_sign = hi_sel_i ? data_i[DATA_W-1] : sign_q;

    shf_signcnt #(.DW(DATA_W), .CW(CNT_W)) u_signcnt (
        .word_i  (data_i),
        .sign_i  (cnt_sign),
        .count_o (cnt)
    );

    assign all_sign   = (cnt == CNT_W'(DATA_W));
    assign exp_hi_val = AMT_W'(0) - (AMT_W'(cnt) - AMT_W'(1));
    assign exp_lo_val = AMT_W'(0) - (AMT_W'(DATA_W - 1) + AMT_W'(cnt));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_HI_PART, S_HI_FULL: begin
                if (is_exp_hi) begin
                    state_d = all_sign ? S_HI_FULL : S_HI_PART;
                end else if (op_i != OP_NOP && op_i <= OP_EXP) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            exp_q    <= '0;
            sign_q   <= 1'b0;
        end else begin
            if (is_shift) begin
                result_q <= merged;
            end
            if (is_exp_hi) begin
                exp_q  <= exp_hi_val;
                sign_q <= data_i[DATA_W-1];
            end else if (is_exp_lo && state_q == S_HI_FULL) begin
                exp_q <= exp_lo_val;
            end
        end
    end

    assign result_o = result_q;
    assign exp_o    = exp_q;

    // R5
    exp_hi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_exp_hi |=> ($signed(exp_q) <= 0 && $signed(exp_q) >= -15));

    // R5
    exp_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_EXP) |=> $stable(result_q));

    // R6
    exp_lo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_exp_lo && state_q == S_HI_FULL) |=>
            ($signed(exp_q) <= -15 && $signed(exp_q) >= -31));

    // R7
    unarmed_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_exp_lo && state_q != S_HI_FULL) |=> $stable(exp_q));

    // R4
    or_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_shift && or_en_i) |=> ((result_q & $past(result_q)) == $past(result_q)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NOP || op_i > OP_EXP) |=> ($stable(result_q) && $stable(exp_q)));
endmodule

// File: tb/shf_unit_tb.sv
module shf_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [15:0] data_i = '0;
    logic [7:0]  amt_i = '0;
    logic        hi_sel_i = 1'b0;
    logic        or_en_i = 1'b0;
    logic [31:0] result_o;
    logic [7:0]  exp_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] m_res = '0;
    int          m_exp = 0;
    bit          m_armed = 0;
    bit          m_sign = 0;

    always #10 clk = ~clk;

    shf_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .data_i(data_i), .amt_i(amt_i),
        .hi_sel_i(hi_sel_i), .or_en_i(or_en_i), .result_o(result_o), .exp_o(exp_o)
    );

    function automatic logic [31:0] place(logic [15:0] d, bit hi, bit ar);
        if (hi) return {d, 16'h0};
        if (ar && d[15]) return {16'hFFFF, d};
        return {16'h0, d};
    endfunction

    function automatic logic [31:0] mshift(logic [31:0] v, int amt, bit ar);
        int k;
        if (amt >= 0) return (amt >= 32) ? 32'h0 : (v << amt);
        k = -amt;
        if (ar) return (k >= 32) ? {32{v[31]}} : 32'($signed(v) >>> k);
        return (k >= 32) ? 32'h0 : (v >> k);
    endfunction

    function automatic int lead(logic [15:0] w, bit s);
        int n = 0;
        for (int i = 15; i >= 0; i--) begin
            if (w[i] != s) break;
            n++;
        end
        return n;
    endfunction

    task automatic model(int op, logic [15:0] d, int amt, bit hi, bit oe);
        logic [31:0] sh;
        bit ar;
        int a;
        if (op >= 1 && op <= 4) begin
            ar = (op == 2) || ((op == 3 || op == 4) && hi);
            a = (op == 3) ? -m_exp : (op == 4) ? m_exp : amt;
            sh = mshift(place(d, hi, ar), a, ar);
            m_res = sh | (oe ? m_res : 32'h0);
            m_armed = 0;
        end else if (op == 5) begin
            if (hi) begin
                m_exp = -(lead(d, d[15]) - 1);
                m_sign = d[15];
                m_armed = (lead(d, d[15]) == 16);
            end else begin
                if (m_armed) m_exp = -15 - lead(d, m_sign);
                m_armed = 0;
            end
        end
    endtask

    task automatic compare(string tag);
        checks++;
        if (result_o !== m_res || exp_o !== 8'(m_exp)) begin
            errors++;
            $display("FAIL %s: result=%h exp=%0d expected result=%h exp=%0d",
                     tag, result_o, $signed(exp_o), m_res, m_exp);
        end
    endtask

    task automatic do_op(int op, logic [15:0] d, int amt, bit hi, bit oe, string tag);
        op_i = 3'(op); data_i = d; amt_i = 8'(amt); hi_sel_i = hi; or_en_i = oe;
        model(op, d, amt, hi, oe);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");

        do_op(1, 16'h1234, 0, 1, 0, "R2 hi place");
        do_op(1, 16'h1234, 4, 0, 0, "R2 lo left");
        do_op(1, 16'hF234, -20, 1, 0, "R2 right zero fill");
        do_op(1, 16'hFFFF, 40, 0, 0, "R2 left 40");
        do_op(1, 16'hFFFF, -128, 1, 0, "R2 right 128");
        do_op(2, 16'h8001, -4, 1, 0, "R3 arith right");
        do_op(2, 16'h8000, 0, 0, 0, "R3 lo sign extend");
        do_op(2, 16'h8000, -40, 1, 0, "R3 right 40");
        do_op(2, 16'h4000, 3, 1, 0, "R3 arith left");
        do_op(1, 16'hABCD, 0, 1, 0, "R4 first half");
        do_op(1, 16'h1234, 0, 0, 1, "R4 or second half");
        do_op(5, 16'h0FFF, 0, 1, 0, "R5 exp -3");
        do_op(5, 16'h1234, 0, 0, 0, "R7 unarmed low");
        do_op(5, 16'hFFFF, 0, 1, 0, "R5 exp -15");
        do_op(5, 16'h7FFF, 0, 1, 0, "R5 exp 0 pos");
        do_op(5, 16'h8000, 0, 1, 0, "R5 exp 0 neg");
        do_op(5, 16'h0000, 0, 1, 0, "R6 hi zero");
        do_op(5, 16'h1234, 0, 0, 0, "R6 low -18");
        do_op(3, 16'h0000, 0, 1, 0, "R8 norm hi");
        do_op(3, 16'h1234, 0, 0, 1, "R8 norm lo or");
        do_op(5, 16'hFFFF, 0, 1, 0, "R6 hi ones");
        do_op(5, 16'hFFFF, 0, 0, 0, "R6 low -31");
        do_op(5, 16'hFFFF, 0, 1, 0, "R7 rearm");
        do_op(1, 16'h0001, 1, 0, 0, "R7 disarming op");
        do_op(5, 16'h0000, 0, 0, 0, "R7 low after disarm");
        do_op(5, 16'h0FFF, 0, 1, 0, "R8 setup");
        do_op(3, 16'h0FFF, 0, 1, 0, "R8 single norm");
        do_op(4, 16'h8000, 0, 1, 0, "R9 denorm hi");
        do_op(4, 16'h8000, 0, 0, 0, "R9 denorm lo");
        do_op(0, 16'hFFFF, 5, 1, 1, "R10 nop");
        do_op(7, 16'hFFFF, 5, 0, 1, "R10 code 7");
        do_op(6, 16'h1111, 2, 1, 0, "R10 code 6");
        for (int i = 0; i < 400; i++) begin
            do_op($urandom_range(0, 7), 16'($urandom), int'($signed(8'($urandom))),
                  1'($urandom), 1'($urandom), "R2-R10 mixed");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule